// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit sits between an execute stage and a synchronous data memory that is one word wide and has one write strobe per byte. For each request it takes a 6-bit operation code, a base register value and a signed 16-bit displacement. From these it forms the byte address, and then drives the word address, the per-byte write strobes and the lane-aligned write data to the memory in the same cycle. When the memory returns a word one cycle later, the unit extracts the addressed byte and sign-extends it for byte loads, or passes the whole word through for word loads.

Lanes follow big-endian order. The byte whose address is the word address is the most significant byte of the word. Sub-word data always sits in the low bits of the register. A word access whose address is not a multiple of four does not reach the memory. Instead, a fault pulse comes back with the same timing as a load response.

Top module: `be_lane_lsu`

## Requirements
- R1: The effective byte address is the base plus the offset sign-extended from bit 15. When `mem_en` is high, `mem_addr` equals bits 31:2 of that address, in the same cycle as the request.
- R2: Only four codes start an access: 35 loads a word, 43 stores a word, 32 loads a byte and 40 stores a byte. For any other code, or when `req_valid` is low, `mem_en` is low, all strobes are low, and the next cycle has no response and no fault.
- R3: An aligned word store raises all four strobes and drives `mem_wdata` equal to `req_wdata`.
- R4: A byte store raises exactly one strobe, and the other three bytes in memory keep their values. Address bits 1:0 select the strobe: 0 selects `mem_we[3]` (data bits 31:24), 1 selects bit 2, 2 selects bit 1 and 3 selects bit 0. Bits 7:0 of `req_wdata` are copied onto every lane of `mem_wdata`.
- R5: An aligned word load raises `rsp_valid` for one cycle, one cycle after the request. `rsp_data` then carries the whole memory word, with the byte at the word address in bits 31:24.
- R6: A byte load returns the addressed byte in bits 7:0 of `rsp_data`, with bit 7 copied into bits 31:8. The lane mapping is the same as in R4.
- R7: A word access whose address bits 1:0 are not zero leaves `mem_en` and every strobe low. It raises `rsp_fault` for one cycle, one cycle after the request, and raises no `rsp_valid`.
- R8: Byte accesses never fault, whatever the low address bits are.
- R9: While reset is active, and in the cycles after reset before any request, `rsp_valid` and `rsp_fault` are low.
- R10: A negative offset subtracts from the base. For example, a base of 0x100 with an offset of 0xFF9C addresses byte 0x9C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 6 | Operation code (35, 43, 32, 40) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_en | output | 1 | Memory access enable |
| mem_addr | output | 30 | Word address to memory |
| mem_we | output | 4 | Byte write strobes, bit 3 = most significant lane |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, valid one cycle after `mem_en` |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Aligned and extended load result |
| rsp_fault | output | 1 | Misaligned word access pulse |

## Verification
The memory-side outputs (`mem_en`, `mem_addr`, `mem_we`, `mem_wdata`) are combinational from the request. The bench therefore samples them one time unit after it drives a request at the falling edge, before the next rising edge. `rsp_valid`, `rsp_data` and `rsp_fault` are due one rising edge later: one edge for the memory read register and the response flops together. The bench samples them just after the following falling edge. Byte-store merging and misaligned-store suppression are confirmed by reading the word back through a later word load.

// File: rtl/be_lane_lsu_pkg.sv
package be_lane_lsu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OPC_W  = 6;

  localparam logic [OPC_W-1:0] OPC_LDW = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STW = 6'd43;
  localparam logic [OPC_W-1:0] OPC_LDB = 6'd32;
  localparam logic [OPC_W-1:0] OPC_STB = 6'd40;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_LDB  = 3'd1,
    ACC_LDW  = 3'd2,
    ACC_STB  = 3'd3,
    ACC_STW  = 3'd4
  } acc_e;
endpackage

// File: rtl/be_lane_lsu_rstsync.sv
module be_lane_lsu_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/be_lane_lsu_agen.sv
module be_lane_lsu_agen
  import be_lane_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned LANE_BITS = 2
) (
  input  logic                 valid,
  input  logic [OPC_W-1:0]     opcode,
  input  logic [ADDR_W-1:0]    base,
  input  logic [OFF_W-1:0]     offset,
  output acc_e                 kind,
  output logic [ADDR_W-1:0]    eff_addr,
  output logic [LANE_BITS-1:0] lane,
  output logic                 misaligned,
  output logic                 issue
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic is_word;

  always_comb begin
    kind = ACC_NONE;
    if (valid) begin
      unique case (opcode)
        OPC_LDW: kind = ACC_LDW;
        OPC_STW: kind = ACC_STW;
        OPC_LDB: kind = ACC_LDB;
        OPC_STB: kind = ACC_STB;
        default: kind = ACC_NONE;
      endcase
    end
  end

  assign eff_addr   = base + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane       = eff_addr[LANE_BITS-1:0];
  assign is_word    = (kind == ACC_LDW) || (kind == ACC_STW);
  assign misaligned = is_word && (lane != '0);
  assign issue      = (kind != ACC_NONE) && !misaligned;
endmodule

// File: rtl/be_lane_lsu_wlane.sv
module be_lane_lsu_wlane
  import be_lane_lsu_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LANE_BITS = 2
) (
  input  logic                 issue,
  input  acc_e                 kind,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-1:0]    src,
  output logic [DATA_W/BYTE_W-1:0] we,
  output logic [DATA_W-1:0]    wdata
);
  localparam int unsigned BYTES = DATA_W / BYTE_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam logic [LANE_BITS-1:0] MY_OFS = LANE_BITS'(BYTES - 1 - g);
    logic hit_byte;
    assign hit_byte = (kind == ACC_STB) && (lane == MY_OFS);
    assign we[g] = issue && ((kind == ACC_STW) || hit_byte);
    assign wdata[g*BYTE_W +: BYTE_W] =
      (kind == ACC_STW) ? src[g*BYTE_W +: BYTE_W] : src[BYTE_W-1:0];
  end
endmodule

// File: rtl/be_lane_lsu_rlane.sv
module be_lane_lsu_rlane
  import be_lane_lsu_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LANE_BITS = 2
) (
  input  logic [DATA_W-1:0]    rdata,
  input  logic [LANE_BITS-1:0] lane,
  input  logic                 byte_sel,
  output logic [DATA_W-1:0]    result
);
  localparam int unsigned BYTES = DATA_W / BYTE_W;
  localparam int unsigned EXT_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int k = 0; k < BYTES; k++) begin
      if (lane == LANE_BITS'(BYTES - 1 - k)) picked = rdata[k*BYTE_W +: BYTE_W];
    end
  end

  assign result = byte_sel ? {{EXT_W{picked[BYTE_W-1]}}, picked} : rdata;
endmodule

// File: rtl/be_lane_lsu.sv
module be_lane_lsu
  import be_lane_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BYTES     = DATA_W / BYTE_W,
  localparam int unsigned LANE_BITS = $clog2(BYTES),
  localparam int unsigned WADDR_W   = ADDR_W - LANE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [OPC_W-1:0]   req_opcode,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_en,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]   mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_fault
);
  logic                 rst_sync_n;
  acc_e                 kind;
  logic [ADDR_W-1:0]    eff_addr;
  logic [LANE_BITS-1:0] lane;
  logic                 misaligned;
  logic                 issue;
  logic                 load_go;

  logic                 pend_q, pend_d;
  logic                 fault_q, fault_d;
  logic                 bsel_q, bsel_d;
  logic [LANE_BITS-1:0] lane_q, lane_d;

  be_lane_lsu_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  be_lane_lsu_agen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_BITS(LANE_BITS)
  ) u_agen (
    .valid      (req_valid),
    .opcode     (req_opcode),
    .base       (req_base),
    .offset     (req_offset),
    .kind       (kind),
    .eff_addr   (eff_addr),
    .lane       (lane),
    .misaligned (misaligned),
    .issue      (issue)
  );

  be_lane_lsu_wlane #(.DATA_W(DATA_W), .LANE_BITS(LANE_BITS)) u_wlane (
    .issue (issue),
    .kind  (kind),
    .lane  (lane),
    .src   (req_wdata),
    .we    (mem_we),
    .wdata (mem_wdata)
  );

  assign mem_en   = issue;
  assign mem_addr = eff_addr[ADDR_W-1:LANE_BITS];
  assign load_go  = issue && ((kind == ACC_LDW) || (kind == ACC_LDB));

  always_comb begin
    pend_d  = load_go;
    fault_d = misaligned;
    lane_d  = lane_q;
    bsel_d  = bsel_q;
    if (load_go) begin
      lane_d = lane;
      bsel_d = (kind == ACC_LDB);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q  <= 1'b0;
      fault_q <= 1'b0;
      lane_q  <= '0;
      bsel_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      fault_q <= fault_d;
      lane_q  <= lane_d;
      bsel_q  <= bsel_d;
    end
  end

  be_lane_lsu_rlane #(.DATA_W(DATA_W), .LANE_BITS(LANE_BITS)) u_rlane (
    .rdata    (mem_rdata),
    .lane     (lane_q),
    .byte_sel (bsel_q),
    .result   (rsp_data)
  );

  assign rsp_valid = pend_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/be_lane_lsu_chk.sv
module be_lane_lsu_chk
  import be_lane_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 16,
  localparam int unsigned BYTES     = DATA_W / BYTE_W,
  localparam int unsigned LANE_BITS = $clog2(BYTES),
  localparam int unsigned WADDR_W   = ADDR_W - LANE_BITS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [OPC_W-1:0]   req_opcode,
  input logic [ADDR_W-1:0]  req_base,
  input logic [OFF_W-1:0]   req_offset,
  input logic [DATA_W-1:0]  req_wdata,
  input logic               mem_en,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [BYTES-1:0]   mem_we,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_data,
  input logic               rsp_fault
);
  logic              armed_q;
  logic [ADDR_W-1:0] ea;
  logic              w_acc, stw, stb, known, bad_word, ld_sent, ldb_sent;
  logic [LANE_BITS-1:0] sb_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign ea       = req_base + ADDR_W'($signed(req_offset));
  assign stw      = req_valid && (req_opcode == OPC_STW);
  assign stb      = req_valid && (req_opcode == OPC_STB);
  assign w_acc    = req_valid && ((req_opcode == OPC_LDW) || stw);
  assign known    = req_valid && ((req_opcode == OPC_LDW) || (req_opcode == OPC_STW) ||
                                  (req_opcode == OPC_LDB) || (req_opcode == OPC_STB));
  assign bad_word = w_acc && (ea[LANE_BITS-1:0] != '0);
  assign ld_sent  = mem_en && (mem_we == '0);
  assign ldb_sent = ld_sent && (req_opcode == OPC_LDB);
  assign sb_bit   = LANE_BITS'(BYTES - 1) - ea[LANE_BITS-1:0];

  // R1
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr == ea[ADDR_W-1:LANE_BITS]);

  // R2
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (!mem_en && mem_we == '0));

  // R3
  word_store_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stw && !bad_word) |-> (&mem_we && mem_wdata == req_wdata));

  // R4
  byte_store_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> ($countones(mem_we) == 1 && mem_we[sb_bit]));

  // R5
  load_rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sent |=> rsp_valid);

  // R5
  load_rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rsp_valid) |-> $past(ld_sent));

  // R6
  byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rsp_valid && $past(ldb_sent)) |->
      rsp_data[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){rsp_data[BYTE_W-1]}});

  // R7
  misalign_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |-> (!mem_en && mem_we == '0));

  // R7
  fault_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (rsp_fault == $past(bad_word)));
endmodule

bind be_lane_lsu be_lane_lsu_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_opcode (req_opcode),
  .req_base   (req_base),
  .req_offset (req_offset),
  .req_wdata  (req_wdata),
  .mem_en     (mem_en),
  .mem_addr   (mem_addr),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_fault  (rsp_fault)
);

// File: tb/be_lane_lsu_tb_top.sv
`timescale 1ns/1ps
module be_lane_lsu_tb_top;
  localparam logic [5:0] LDW = 6'd35, STW = 6'd43, LDB = 6'd32, STB = 6'd40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_opcode;
  logic [31:0] req_base;
  logic [15:0] req_offset;
  logic [31:0] req_wdata;
  logic        mem_en;
  logic [29:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_fault;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic        c_en;
  logic [29:0] c_addr;
  logic [3:0]  c_we;
  logic [31:0] c_wdata;
  logic        r_valid;
  logic [31:0] r_data;
  logic        r_fault;

  always #5 clk = ~clk;

  be_lane_lsu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault)
  );

  logic [31:0] ram [0:63];
  always @(posedge clk) begin
    if (mem_en) begin
      for (int i = 0; i < 4; i++)
        if (mem_we[i]) ram[mem_addr[5:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
      mem_rdata <= ram[mem_addr[5:0]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [5:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    req_valid = v; req_opcode = op; req_base = b; req_offset = o; req_wdata = d;
    #1;
    c_en = mem_en; c_addr = mem_addr; c_we = mem_we; c_wdata = mem_wdata;
    @(negedge clk);
    req_valid = 1'b0; req_opcode = 6'd0;
    #1;
    r_valid = rsp_valid; r_data = rsp_data; r_fault = rsp_fault;
  endtask

  task automatic t_reset();
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R9 rsp_fault after reset", 32'(rsp_fault), 32'd0);
    chk("R2 mem_en idle", 32'(mem_en), 32'd0);
  endtask

  task automatic t_word();
    issue(1, STW, 32'h40, 16'h0004, 32'h11223344);
    chk("R1 store word address", 32'(c_addr), 32'h11);
    chk("R3 store word strobes", 32'(c_we), 32'hF);
    chk("R3 store word data", c_wdata, 32'h11223344);
    issue(1, LDW, 32'h44, 16'h0000, 32'h0);
    chk("R5 load word valid", 32'(r_valid), 32'd1);
    chk("R5 load word data", r_data, 32'h11223344);
    chk("R5 load word no fault", 32'(r_fault), 32'd0);
  endtask

  task automatic t_load_byte();
    for (int k = 0; k < 4; k++) begin
      issue(1, LDB, 32'h44, 16'(k), 32'h0);
      chk("R6 load byte positive", r_data, 32'h11 * (k + 1));
      chk("R8 load byte no fault", 32'(r_fault), 32'd0);
    end
    issue(1, STW, 32'h48, 16'h0000, 32'hA0B1C2D3);
    issue(1, LDB, 32'h48, 16'h0000, 32'h0);
    chk("R6 load byte sext lane0", r_data, 32'hFFFFFFA0);
    issue(1, LDB, 32'h48, 16'h0003, 32'h0);
    chk("R6 load byte sext lane3", r_data, 32'hFFFFFFD3);
    issue(1, LDB, 32'h48, 16'h0001, 32'h0);
    chk("R6 load byte sext lane1", r_data, 32'hFFFFFFB1);
  endtask

  task automatic t_store_byte();
    issue(1, STW, 32'h50, 16'h0000, 32'h0);
    for (int k = 0; k < 4; k++) begin
      issue(1, STB, 32'h50, 16'(k), 32'hFFFFFF10 + 32'(k));
      chk("R4 store byte strobe", 32'(c_we), 32'(4'b1000 >> k));
      chk("R4 store byte lane data", 32'(c_wdata[8*(3-k) +: 8]), 32'h10 + 32'(k));
      chk("R8 store byte no fault", 32'(r_fault), 32'd0);
    end
    issue(1, LDW, 32'h50, 16'h0000, 32'h0);
    chk("R4 merged word", r_data, 32'h10111213);
  endtask

  task automatic t_misalign();
    issue(1, STW, 32'h60, 16'h0000, 32'h12345678);
    issue(1, LDW, 32'h60, 16'h0002, 32'h0);
    chk("R7 misaligned load no enable", 32'(c_en), 32'd0);
    chk("R7 misaligned load fault", 32'(r_fault), 32'd1);
    chk("R7 misaligned load no valid", 32'(r_valid), 32'd0);
    issue(1, STW, 32'h61, 16'h0000, 32'hDEADBEEF);
    chk("R7 misaligned store strobes", 32'(c_we), 32'd0);
    chk("R7 misaligned store fault", 32'(r_fault), 32'd1);
    issue(1, LDW, 32'h60, 16'h0000, 32'h0);
    chk("R7 memory untouched", r_data, 32'h12345678);
    chk("R7 fault cleared", 32'(r_fault), 32'd0);
  endtask

  task automatic t_negative();
    issue(1, STW, 32'h100, 16'hFF9C, 32'hCAFEF00D);
    chk("R10 negative offset address", 32'(c_addr), 32'h27);
    issue(1, LDW, 32'h90, 16'h000C, 32'h0);
    chk("R10 negative offset readback", r_data, 32'hCAFEF00D);
  endtask

  task automatic t_ignore();
    issue(1, 6'd0, 32'h44, 16'h0000, 32'hFFFFFFFF);
    chk("R2 unknown code enable", 32'(c_en), 32'd0);
    chk("R2 unknown code strobes", 32'(c_we), 32'd0);
    chk("R2 unknown code no rsp", 32'(r_valid), 32'd0);
    chk("R2 unknown code no fault", 32'(r_fault), 32'd0);
    issue(0, STW, 32'h44, 16'h0000, 32'hFFFFFFFF);
    chk("R2 invalid request strobes", 32'(c_we), 32'd0);
    issue(1, LDW, 32'h44, 16'h0000, 32'h0);
    chk("R2 word unchanged", r_data, 32'h11223344);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_opcode = '0;
    req_base = '0; req_offset = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 t_reset();
    t_word();
    t_load_byte();
    t_store_byte();
    t_misalign();
    t_negative();
    t_ignore();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule